// File: doc/BRIEF.md
# Memory-Controller Performance Counter Bank

This block holds four event counters that a memory controller uses to measure its own activity. Software reaches them through a small word-addressed register port. Each counter has a control word and a count word. The control word sets the counter running, clears it and picks the event it counts through an 8-bit code. The memory controller supplies a vector of event pulses. An event counter adds one in each clock cycle in which the vector bit named by its code is high.

Counter 0 is the master. It counts clock cycles only. When it is disabled, or when it wraps, every counter stops. A wrap also raises a level interrupt, which software uses to gather and restart the bank. An event counter that wraps stops on its own and sets its overflow flag. It raises no interrupt. The clear bit acts differently on counter 0 and on the event counters.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset all counts, overflow flags, enable bits and codes are zero, the interrupt is low, and every control word reads 0x0000_0002 (clear bit 1 set).
- R2: Control word n is at byte offset 4*n and count word n is at 0x20+4*n, with the low two address bits ignored. Read data appears on the cycle after the read request. Reads of any other offset return zero. Writes to count words are ignored.
- R3: While its enable bit (bit 2) is set and the bank is not halted, counter 0 adds one on every clock. Its code field (bits 31:24) always reads 0.
- R4: Counter n (1..3) adds one on each clock in which evtIn[code] is high, its own enable bit and counter 0's enable bit are set, and the bank is not halted. A code at or above NUM_EVT never counts.
- R5: A write to control word 0 clears count 0 and releases the halt only when the stored clear bit is 0 and the written clear bit is 1. That write also clears overflow flag 0 and drops the interrupt. Writing 0 to that bit clears nothing.
- R6: A write to control word n (1..3) with bit 1 at 0 zeroes count n and overflow flag n. The clear bit of that word then reads back 1.
- R7: When counter 0 wraps from all-ones to zero, it sets overflow flag 0 (bit 0) and raises irqOut. All counters then hold their values until the R5 clear.
- R8: When counter n (1..3) wraps, it becomes zero, sets its own overflow flag and ignores further events. It does not raise irqOut.
- R9: While counter 0's enable bit is clear, counters 1 to 3 do not count.
- R10: One write to a control word updates its enable, clear and code fields together. The overflow bit is not writable.
- R11: irqOut is a level. It stays high through all activity other than the R5 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| evtIn | input | NUM_EVT | Event pulses from the memory controller, indexed by code |
| irqOut | output | 1 | Level interrupt from a counter 0 wrap |

## Verification
A write takes effect at the clock edge that samples it. The first event it can affect is the one sampled at the following edge. A count changes at the edge where its event is sampled. Read data is valid after the edge that takes the read request, so the bench samples it at the next falling edge. The interrupt is visible just after the edge where counter 0 wraps. The bench drives every input at a falling edge and counts the rising edges between stimulus and sample, so each expected count follows from the number of driven cycles. Halting counter 0 before each read freezes the values being read.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;
  localparam int NUM_CNT       = 4;
  localparam int EVT_W         = 8;
  localparam int BUS_W         = 32;
  localparam int ADDR_W        = 8;
  localparam int CNT_BASE_WORD = 8;   // count words start at byte 0x20
  localparam int OVF_BIT       = 0;
  localparam int CLR_BIT       = 1;
  localparam int EN_BIT        = 2;
  localparam int CODE_LSB      = 24;

  typedef struct packed {
    logic [NUM_CNT-1:0]            en;
    logic [NUM_CNT-1:0]            clr;
    logic [NUM_CNT-1:0][EVT_W-1:0] code;
  } ctrlStrobe_t;
endpackage

// File: rtl/perf_ctrl.sv
module perf_ctrl
  import perf_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busValid,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [BUS_W-1:0]                busWdata,
  output logic [BUS_W-1:0]                busRdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cntVals,
  input  logic [NUM_CNT-1:0]              ovfFlags,
  output ctrlStrobe_t                     strobes
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int PAD_W  = CODE_LSB - EN_BIT - 1;

  logic [WORD_W-1:0]             wordIdx;
  logic                          wrEn;
  logic                          rdEn;
  logic [NUM_CNT-1:0]            ctrlSel;
  logic [NUM_CNT-1:0]            cntSel;
  logic [NUM_CNT-1:0]            enVec;
  logic [NUM_CNT-1:0]            clrVec;
  logic [NUM_CNT-1:0]            clrRead;
  logic [NUM_CNT-1:0][EVT_W-1:0] codeVec;
  logic [NUM_CNT-1:0][BUS_W-1:0] ctrlWord;
  logic [BUS_W-1:0]              rdNext;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrEn    = busValid && busWrite;
  assign rdEn    = busValid && !busWrite;

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_reg
    logic enQ;
    assign ctrlSel[n] = (wordIdx == WORD_W'(n));
    assign cntSel[n]  = (wordIdx == WORD_W'(CNT_BASE_WORD + n));

    if (n == 0) begin : g_master
      logic clrQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enQ  <= 1'b0;
          clrQ <= 1'b1;
        end else if (wrEn && ctrlSel[n]) begin
          enQ  <= busWdata[EN_BIT];
          clrQ <= busWdata[CLR_BIT];
        end
      end
      // counter 0 clears on a 0 -> 1 transition of its stored clear bit
      assign clrVec[n]  = wrEn && ctrlSel[n] && busWdata[CLR_BIT] && !clrQ;
      assign clrRead[n] = clrQ;
      assign codeVec[n] = '0;
    end else begin : g_event
      logic [EVT_W-1:0] codeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enQ   <= 1'b0;
          codeQ <= '0;
        end else if (wrEn && ctrlSel[n]) begin
          enQ   <= busWdata[EN_BIT];
          codeQ <= busWdata[CODE_LSB +: EVT_W];
        end
      end
      // event counters clear on a written 0; the bit then reads back 1
      assign clrVec[n]  = wrEn && ctrlSel[n] && !busWdata[CLR_BIT];
      assign clrRead[n] = 1'b1;
      assign codeVec[n] = codeQ;
    end

    assign enVec[n]    = enQ;
    assign ctrlWord[n] = {codeVec[n], {PAD_W{1'b0}}, enVec[n], clrRead[n], ovfFlags[n]};
  end

  always_comb begin
    rdNext = '0;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (ctrlSel[n]) rdNext = ctrlWord[n];
      if (cntSel[n])  rdNext = BUS_W'(cntVals[n]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busRdata <= '0;
    else if (rdEn) busRdata <= rdNext;
  end

  assign strobes.en   = enVec;
  assign strobes.clr  = clrVec;
  assign strobes.code = codeVec;
endmodule

// File: rtl/perf_datapath.sv
module perf_datapath
  import perf_bank_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobes,
  input  logic [NUM_EVT-1:0]            evtIn,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVals,
  output logic [NUM_CNT-1:0]            ovfFlags
);
  localparam int EVT_SPACE = 1 << EVT_W;

  logic [EVT_SPACE-1:0] evtSpace;
  logic                 halted;

  for (genvar i = 0; i < EVT_SPACE; i++) begin : g_space
    if (i < NUM_EVT) begin : g_live
      assign evtSpace[i] = evtIn[i];
    end else begin : g_dead
      assign evtSpace[i] = 1'b0;
    end
  end

  // the bank stops while the master is off or has wrapped
  assign halted = !strobes.en[0] || ovfFlags[0];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;
    logic             ovfQ;
    logic             bump;

    if (n == 0) begin : g_cycles
      assign bump = !halted;
    end else begin : g_events
      assign bump = !halted && strobes.en[n] && !ovfQ && evtSpace[strobes.code[n]];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
        ovfQ <= 1'b0;
      end else if (strobes.clr[n]) begin
        cntQ <= '0;
        ovfQ <= 1'b0;
      end else if (bump) begin
        cntQ <= cntQ + 1'b1;
        if (cntQ == '1) ovfQ <= 1'b1;
      end
    end

    assign cntVals[n]  = cntQ;
    assign ovfFlags[n] = ovfQ;
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_bank_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [7:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic               irqOut
);
  ctrlStrobe_t                   strobes;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVals;
  logic [NUM_CNT-1:0]            ovfFlags;

  perf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntVals(cntVals), .ovfFlags(ovfFlags), .strobes(strobes)
  );

  perf_datapath #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evtIn(evtIn),
    .cntVals(cntVals), .ovfFlags(ovfFlags)
  );

  assign irqOut = ovfFlags[0];
endmodule

// File: rtl/perf_bank_checker.sv
module perf_bank_checker
  import perf_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          busValid,
  input logic                          busWrite,
  input logic [7:0]                    busAddr,
  input logic [31:0]                   busWdata,
  input logic [31:0]                   busRdata,
  input logic                          irqOut,
  input logic                          en0,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVals,
  input logic [NUM_CNT-1:0]            ovfFlags
);
  logic [5:0] word;
  logic       anyWrite;
  logic       unmappedRead;
  logic       masterSet;

  assign word         = busAddr[7:2];
  assign anyWrite     = busValid && busWrite;
  assign unmappedRead = busValid && !busWrite &&
                        !(word < 6'(NUM_CNT)) &&
                        !(word >= 6'(CNT_BASE_WORD) && word < 6'(CNT_BASE_WORD + NUM_CNT));
  assign masterSet    = anyWrite && (word == 6'd0) && busWdata[CLR_BIT];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    unmappedRead |=> (busRdata == '0)); // R2

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (en0 && !irqOut && !anyWrite) |=> (cntVals[0] == CNT_W'($past(cntVals[0]) + 1'b1))); // R3

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !anyWrite) |=> $stable(cntVals)); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !masterSet) |=> irqOut); // R11

  for (genvar k = 1; k < NUM_CNT; k++) begin : g_evt
    AST_EVT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlags[k] && !anyWrite) |=> $stable(cntVals[k])); // R8
  end
endmodule

bind perf_counter_bank perf_bank_checker #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .irqOut(irqOut), .en0(strobes.en[0]), .cntVals(cntVals), .ovfFlags(ovfFlags)
);

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;
  localparam int CW = 12;
  localparam int NE = 64;
  localparam int WRAP = 1 << CW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NE-1:0] evtIn = '0;
  logic          irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  perf_counter_bank #(.CNT_W(CW), .NUM_EVT(NE)) uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evtIn(evtIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] ctrlExp(input logic [7:0] code, input bit en,
                                          input bit clr, input bit ovf);
    return {code, 21'd0, en, clr, ovf};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  c3;
    int          exp1, exp2, exp3;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    rd(8'h00, v); check("R1 ctrl0", v, 32'h2);
    rd(8'h04, v); check("R1 ctrl1", v, 32'h2);
    rd(8'h2C, v); check("R1 count3", v, 32'h0);

    // R2 unmapped offsets and read-only count words
    rd(8'h10, v); check("R2 unmapped 0x10", v, 32'h0);
    rd(8'h40, v); check("R2 unmapped 0x40", v, 32'h0);
    wr(8'h24, 32'h0000_0ABC);
    rd(8'h24, v); check("R2 count write ignored", v, 32'h0);

    // R3 cycle counting: enabled from edge A, disabled at edge A+11
    wr(8'h00, 32'hFF00_0004);
    repeat (10) @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h20, v); check("R3 cycle count", v, 32'd11);
    rd(8'h00, v); check("R3 code reads zero", v, ctrlExp(8'h00, 0, 0, 0));
    // R5 a zero write alone clears nothing, a 0->1 clears
    wr(8'h00, 32'h0);
    rd(8'h20, v); check("R5 zero write keeps count", v, 32'd11);
    wr(8'h00, 32'h2);
    rd(8'h20, v); check("R5 rising clear", v, 32'd0);

    // R9 master disabled: event counters stay still
    wr(8'h04, 32'h0400_0004);
    wr(8'h08, 32'h0500_0004);
    c3 = 8'($urandom_range(0, NE - 1));
    wr(8'h0C, {c3, 24'h000004});
    evtIn = '1;
    repeat (20) @(negedge clk);
    evtIn = '0;
    rd(8'h24, v); check("R9 count1 halted", v, 32'd0);
    rd(8'h28, v); check("R9 count2 halted", v, 32'd0);

    // R4 random event patterns
    exp1 = 0; exp2 = 0; exp3 = 0;
    wr(8'h00, 32'h4);
    for (int j = 0; j < 200; j++) begin
      evtIn = {$urandom, $urandom};
      exp1 += int'(evtIn[4]);
      exp2 += int'(evtIn[5]);
      exp3 += int'(evtIn[c3]);
      @(negedge clk);
    end
    evtIn = '0;
    wr(8'h00, 32'h0);
    rd(8'h24, v); check("R4 count1 random", v, 32'(exp1));
    rd(8'h28, v); check("R4 count2 random", v, 32'(exp2));
    rd(8'h2C, v); check("R4 count3 random", v, 32'(exp3));

    // R4 out-of-range code never counts; R6 clear on rewrite of counter 3
    wr(8'h0C, 32'h8000_0004);
    rd(8'h2C, v); check("R6 count3 cleared", v, 32'd0);
    wr(8'h00, 32'h4);
    evtIn = '1;
    repeat (10) @(negedge clk);
    evtIn = '0;
    wr(8'h00, 32'h0);
    rd(8'h2C, v); check("R4 high code idle", v, 32'd0);
    rd(8'h24, v); check("R4 count1 ten more", v, 32'(exp1 + 10));

    // R6 clear on counter 1, clear bit reads back 1; R10 fields together
    wr(8'h04, 32'h0400_0004);
    rd(8'h24, v); check("R6 count1 cleared", v, 32'd0);
    rd(8'h04, v); check("R10 ctrl1 fields", v, ctrlExp(8'h04, 1, 1, 0));

    // R7 master wrap: counter1 every cycle, counter2 every other cycle
    wr(8'h08, 32'h0500_0004);
    wr(8'h00, 32'h6);
    for (int j = 0; j < WRAP; j++) begin
      evtIn = '0;
      evtIn[4] = 1'b1;
      evtIn[5] = (j % 2 == 0);
      @(negedge clk);
    end
    check("R7 irq raised", {31'd0, irqOut}, 32'd1);
    evtIn = '1;
    repeat (20) @(negedge clk);
    evtIn = '0;
    check("R11 irq held", {31'd0, irqOut}, 32'd1);
    rd(8'h20, v); check("R7 count0 wrapped", v, 32'd0);
    rd(8'h00, v); check("R7 ctrl0 overflow", v, ctrlExp(8'h00, 1, 1, 1));
    rd(8'h28, v); check("R7 count2 halted", v, 32'(WRAP / 2));
    rd(8'h24, v); check("R8 count1 wrapped", v, 32'd0);
    rd(8'h04, v); check("R8 ctrl1 overflow", v, ctrlExp(8'h04, 1, 1, 1));

    // R11 a zero write does not release; R5 rising clear releases
    wr(8'h00, 32'h4);
    check("R11 irq after zero write", {31'd0, irqOut}, 32'd1);
    wr(8'h00, 32'h6);
    check("R5 irq released", {31'd0, irqOut}, 32'd0);

    // R8 event counter wraps on its own, no interrupt
    evtIn = '0;
    evtIn[5] = 1'b1;
    repeat (WRAP / 2 + 10) @(negedge clk);
    check("R8 no irq", {31'd0, irqOut}, 32'd0);
    evtIn = '0;
    wr(8'h00, 32'h0);
    rd(8'h20, v); check("R3 count0 after restart", v, 32'(WRAP / 2 + 11));
    rd(8'h28, v); check("R8 count2 frozen", v, 32'd0);
    rd(8'h08, v); check("R8 ctrl2 overflow", v, ctrlExp(8'h05, 1, 1, 1));

    // R10 overflow bit is not writable
    wr(8'h08, 32'h0500_0006);
    rd(8'h08, v); check("R10 overflow kept", v, ctrlExp(8'h05, 1, 1, 1));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule